// File: doc/BRIEF.md
# Multi-Context Reconfigurable Logic Array

This block is a programmable logic array whose configuration can be swapped at run time. A programmable AND plane builds product terms from the inputs, each in true and complement form. A programmable OR plane sums chosen product terms into each output. A small macrocell on each output selects whether that output is combinational or registered. Each programming point is a multiplexer. Its select comes from a one-bit active configuration register. A cleared register passes the neutral value of its plane.

Up to sixteen complete configurations (contexts) sit in one narrow single-port RAM inside the block. Both logic planes are shared by all contexts. A host loads contexts one RAM word at a time. A switch request names a context. The context controller then reads that context word by word into a shadow register and loads every active node register at once on the final word. The controller also arbitrates the RAM between host writes and switch reads.

Top module: `pla_multictx`

## Requirements
- R1: Product term p is the AND of the literals whose node bits are set. The true form of input i uses configuration bit p*2*NUM_IN+2*i and the complement form uses bit p*2*NUM_IN+2*i+1.
- R2: Output sum o is the OR of the product terms whose node bits are set. Product term p feeds sum o through configuration bit AND_BITS+o*NUM_PT+p, where AND_BITS=NUM_PT*2*NUM_IN.
- R3: A cleared node passes 1 into an AND and 0 into an OR. A product term with no set bits is 1, and an output with no set OR bits is 0.
- R4: Configuration bit AND_BITS+OR_BITS+o selects the type of output o. 1 makes it combinational. 0 makes it registered, so the output shows the sum from one clock earlier.
- R5: A context takes WORDS=ceil(CFG_BITS/RAM_W) RAM words starting at word address ctx*WORDS. Word k carries configuration bits k*RAM_W upward, LSB first. busy rises after the edge that samples sw_req, falls WORDS+2 clock edges after that edge, and the new configuration takes effect on that same edge.
- R6: While busy is high the array keeps running on the previous context, unchanged, with no mix of old and new bits.
- R7: wr_ready is low while busy is high. A host write is stored on an edge where wr_valid and wr_ready are both high. A write held during a switch completes after the switch.
- R8: When sw_req and a host write arrive in the same cycle, the write is stored first and the switch reads the new data. An sw_req sampled while busy is high is ignored.
- R9: Reset clears every active node register, so all outputs read 0, busy reads 0 and wr_ready reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Pulse that requests a context switch |
| sw_ctx | input | CTX_W (4) | Index of the context to switch to |
| busy | output | 1 | A switch is pending or in progress |
| wr_valid | input | 1 | Host write request |
| wr_addr | input | ADDR_W (9) | Word address in the context RAM |
| wr_data | input | RAM_W (16) | Word to store |
| wr_ready | output | 1 | Host write can be accepted this cycle |
| pla_in | input | NUM_IN (8) | Array inputs |
| pla_out | output | NUM_OUT (4) | Array outputs |

## Verification
Two things can fall in the same cycle: a host write and a switch. Either the write and sw_req are raised on one edge, or a write is issued while a switch streams words from the RAM. The bench provokes the first by rewriting the first word of the target context together with the request. The outputs must then follow the corrected word. It provokes the second by issuing a write a few cycles into a switch. wr_ready must read low, and a later switch to that context must show the written word in effect while the running switch shows the old contents. A scoreboard also compares the outputs every cycle of each switch against the old context.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE   = 2'd0,
    CTL_READ   = 2'd1,
    CTL_COMMIT = 2'd2
  } ctl_state_t;

  function automatic int words_for(input int bits, input int width);
    return (bits + width - 1) / width;
  endfunction

endpackage

// File: rtl/pla_ctx_ram.sv
module pla_ctx_ram #(
  parameter int WIDTH  = 16,
  parameter int DEPTH  = 336,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic             in_range;

  assign in_range = {1'b0, addr} < (ADDR_W+1)'(DEPTH);

  always_ff @(posedge clk) begin
    if (we && in_range) mem[addr] <= wdata;
    if (re && in_range) rdata <= mem[addr];
  end

  // R7: the single port never sees a host write and a switch read together
  p_single_port_r7: assert property (@(posedge clk) disable iff (rst)
    !(we && re));

endmodule

// File: rtl/pla_ctx_ctrl.sv
module pla_ctx_ctrl
  import pla_pkg::*;
#(
  parameter int CFG_BITS = 324,
  parameter int RAM_W    = 16,
  parameter int WORDS    = 21,
  parameter int CTX_W    = 4,
  parameter int ADDR_W   = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_req,
  input  logic [CTX_W-1:0]    sw_ctx,
  output logic                busy,
  input  logic                wr_valid,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [RAM_W-1:0]    wr_data,
  output logic                wr_ready,
  output logic                ram_we,
  output logic                ram_re,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [RAM_W-1:0]    ram_wdata,
  input  logic [RAM_W-1:0]    ram_rdata,
  output logic [CFG_BITS-1:0] cfg
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int SHW   = WORDS * RAM_W;

  ctl_state_t            state_q;
  logic                  pend_q;
  logic [CTX_W-1:0]      tgt_q;
  logic [IDX_W-1:0]      idx_q;
  logic [SHW-1:0]        shadow_q;
  logic [SHW-1:0]        merged;
  logic [CFG_BITS-1:0]   cfg_q;
  logic [ADDR_W-1:0]     rd_addr;

  assign busy      = pend_q || (state_q != CTL_IDLE);
  assign wr_ready  = (state_q == CTL_IDLE) && !pend_q;
  assign ram_we    = wr_valid && wr_ready;
  assign ram_re    = (state_q == CTL_READ);
  assign rd_addr   = ADDR_W'(int'(tgt_q) * WORDS + int'(idx_q));
  assign ram_addr  = ram_re ? rd_addr : wr_addr;
  assign ram_wdata = wr_data;
  assign cfg       = cfg_q;

  // final word arrives straight from the RAM in the commit cycle
  always_comb begin
    merged = shadow_q;
    merged[(WORDS-1)*RAM_W +: RAM_W] = ram_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= CTL_IDLE;
      pend_q   <= 1'b0;
      tgt_q    <= '0;
      idx_q    <= '0;
      shadow_q <= '0;
      cfg_q    <= '0;
    end else begin
      case (state_q)
        CTL_IDLE: begin
          if (pend_q) begin
            pend_q  <= 1'b0;
            idx_q   <= '0;
            state_q <= CTL_READ;
          end else if (sw_req) begin
            pend_q <= 1'b1;
            tgt_q  <= sw_ctx;
          end
        end
        CTL_READ: begin
          if (idx_q != '0)
            shadow_q[(int'(idx_q) - 1) * RAM_W +: RAM_W] <= ram_rdata;
          if (int'(idx_q) == WORDS - 1) state_q <= CTL_COMMIT;
          else                          idx_q   <= idx_q + 1'b1;
        end
        CTL_COMMIT: begin
          cfg_q   <= merged[CFG_BITS-1:0];
          state_q <= CTL_IDLE;
        end
        default: state_q <= CTL_IDLE;
      endcase
    end
  end

  // checker-side counter for the switch window
  logic [15:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else           busy_cnt <= '0;
  end

  // R5: a switch lasts exactly WORDS+2 edges
  p_switch_latency_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == 16'(WORDS + 2)));

  // R5: the target context cannot move while words stream in
  p_target_held_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == CTL_READ) |=> $stable(tgt_q));

  // R6: active nodes only change on the commit edge
  p_atomic_update_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q != CTL_COMMIT) |=> $stable(cfg_q));

endmodule

// File: rtl/pla_logic_planes.sv
module pla_logic_planes #(
  parameter int NUM_IN  = 8,
  parameter int NUM_PT  = 16,
  parameter int NUM_OUT = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_IN-1:0]          pla_in,
  input  logic [NUM_PT*2*NUM_IN-1:0] and_cfg,
  input  logic [NUM_OUT*NUM_PT-1:0]  or_cfg,
  output logic [NUM_OUT-1:0]         sum
);

  localparam int LIT_W = 2 * NUM_IN;

  logic [LIT_W-1:0]  lits;
  logic [NUM_PT-1:0] term;

  // literal 2i is the true input, 2i+1 its complement
  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign lits[2*i]   = pla_in[i];
    assign lits[2*i+1] = ~pla_in[i];
  end

  // AND plane: a cleared node forces its literal to the neutral 1
  for (genvar p = 0; p < NUM_PT; p++) begin : g_and
    logic [LIT_W-1:0] node_out;
    assign node_out = lits | ~and_cfg[p*LIT_W +: LIT_W];
    assign term[p]  = &node_out;

    // R3: an empty product term evaluates to 1
    p_empty_term_r3: assert property (@(posedge clk) disable iff (rst)
      (and_cfg[p*LIT_W +: LIT_W] == '0) |-> term[p]);
  end

  // OR plane: a cleared node forces its term to the neutral 0
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_or
    logic [NUM_PT-1:0] node_out;
    assign node_out = term & or_cfg[o*NUM_PT +: NUM_PT];
    assign sum[o]   = |node_out;

    // R3: an output with no connected terms stays 0
    p_empty_sum_r3: assert property (@(posedge clk) disable iff (rst)
      (or_cfg[o*NUM_PT +: NUM_PT] == '0) |-> !sum[o]);
  end

endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] sum,
  input  logic [NUM_OUT-1:0] comb_sel,
  output logic [NUM_OUT-1:0] pla_out
);

  logic [NUM_OUT-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) reg_q <= '0;
    else     reg_q <= sum;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_cell
    assign pla_out[o] = comb_sel[o] ? sum[o] : reg_q[o];

    // R4: a registered output repeats the previous cycle's sum
    p_registered_path_r4: assert property (@(posedge clk) disable iff (rst)
      !comb_sel[o] |-> (pla_out[o] == $past(sum[o])));
  end

endmodule

// File: rtl/pla_multictx.sv
module pla_multictx #(
  parameter int NUM_IN  = 8,
  parameter int NUM_PT  = 16,
  parameter int NUM_OUT = 4,
  parameter int NUM_CTX = 16,
  parameter int RAM_W   = 16,
  localparam int AND_BITS = NUM_PT * 2 * NUM_IN,
  localparam int OR_BITS  = NUM_OUT * NUM_PT,
  localparam int CFG_BITS = AND_BITS + OR_BITS + NUM_OUT,
  localparam int WORDS    = pla_pkg::words_for(CFG_BITS, RAM_W),
  localparam int DEPTH    = NUM_CTX * WORDS,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CTX_W    = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_req,
  input  logic [CTX_W-1:0]   sw_ctx,
  output logic               busy,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [RAM_W-1:0]   wr_data,
  output logic               wr_ready,
  input  logic [NUM_IN-1:0]  pla_in,
  output logic [NUM_OUT-1:0] pla_out
);

  logic                ram_we;
  logic                ram_re;
  logic [ADDR_W-1:0]   ram_addr;
  logic [RAM_W-1:0]    ram_wdata;
  logic [RAM_W-1:0]    ram_rdata;
  logic [CFG_BITS-1:0] cfg;
  logic [NUM_OUT-1:0]  sum;

  pla_ctx_ram #(
    .WIDTH (RAM_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (ram_we),
    .re   (ram_re),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  pla_ctx_ctrl #(
    .CFG_BITS(CFG_BITS),
    .RAM_W   (RAM_W),
    .WORDS   (WORDS),
    .CTX_W   (CTX_W),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sw_req   (sw_req),
    .sw_ctx   (sw_ctx),
    .busy     (busy),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .ram_we   (ram_we),
    .ram_re   (ram_re),
    .ram_addr (ram_addr),
    .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata),
    .cfg      (cfg)
  );

  pla_logic_planes #(
    .NUM_IN (NUM_IN),
    .NUM_PT (NUM_PT),
    .NUM_OUT(NUM_OUT)
  ) u_planes (
    .clk    (clk),
    .rst    (rst),
    .pla_in (pla_in),
    .and_cfg(cfg[AND_BITS-1:0]),
    .or_cfg (cfg[AND_BITS +: OR_BITS]),
    .sum    (sum)
  );

  pla_macrocell #(
    .NUM_OUT(NUM_OUT)
  ) u_cells (
    .clk     (clk),
    .rst     (rst),
    .sum     (sum),
    .comb_sel(cfg[AND_BITS+OR_BITS +: NUM_OUT]),
    .pla_out (pla_out)
  );

  // R9: the first cycle after reset shows a cleared array
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pla_out == '0) && !busy && wr_ready);

  // R7: the host port is closed for the whole switch
  p_write_stall_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !wr_ready);

endmodule

// File: tb/tb_pla_multictx.sv
`timescale 1ns/1ps
module tb_pla_multictx;

  localparam int NI = 8, NP = 16, NO = 4, W = 16;
  localparam int ANDB = NP*2*NI, ORB = NO*NP, NB = ANDB+ORB+NO;
  localparam int WORDS = (NB + W - 1) / W;
  localparam int AW = 9;

  logic clk = 0, rst = 1, sw_req = 0, wr_valid = 0;
  logic [3:0] sw_ctx = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [NI-1:0] pla_in = '0;
  logic busy, wr_ready;
  logic [NO-1:0] pla_out;

  always #2 clk = ~clk;

  pla_multictx dut (
    .clk(clk), .rst(rst), .sw_req(sw_req), .sw_ctx(sw_ctx), .busy(busy),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .pla_in(pla_in), .pla_out(pla_out));

  typedef struct { logic [NO-1:0] exp; string tag; } item_t;
  item_t sbq[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [NB-1:0] cur_cfg = '0;
  logic [NI-1:0] cur_in = '0;

  function automatic logic [NO-1:0] eval(logic [NB-1:0] c, logic [NI-1:0] x);
    logic [NP-1:0] t;
    logic [NO-1:0] s;
    for (int p = 0; p < NP; p++) begin
      t[p] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (c[p*2*NI+2*i])   t[p] = t[p] & x[i];
        if (c[p*2*NI+2*i+1]) t[p] = t[p] & ~x[i];
      end
    end
    for (int o = 0; o < NO; o++) begin
      s[o] = 1'b0;
      for (int p = 0; p < NP; p++) if (c[ANDB+o*NP+p]) s[o] = s[o] | t[p];
    end
    return s;
  endfunction

  function automatic logic [NB-1:0] lit(logic [NB-1:0] c, int p, int i, int comp);
    c[p*2*NI+2*i+comp] = 1'b1;
    return c;
  endfunction

  function automatic logic [NB-1:0] conn(logic [NB-1:0] c, int o, int p);
    c[ANDB+o*NP+p] = 1'b1;
    return c;
  endfunction

  function automatic logic [W-1:0] word_of(logic [NB-1:0] c, int k);
    logic [WORDS*W-1:0] pad;
    pad = '0;
    pad[NB-1:0] = c;
    return pad[k*W +: W];
  endfunction

  function void push(logic [NO-1:0] e, string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_run++;
      if (pla_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: pla_out=%b expected %b", it.tag, pla_out, it.exp);
      end
    end
  end

  task automatic set_in(logic [NI-1:0] x, string tag);
    logic [NO-1:0] old_s, new_s, comb;
    @(posedge clk); #1;
    old_s = eval(cur_cfg, cur_in);
    new_s = eval(cur_cfg, x);
    comb  = cur_cfg[ANDB+ORB +: NO];
    pla_in = x;
    cur_in = x;
    push((new_s & comb) | (old_s & ~comb), tag);
    @(posedge clk); #1;
    push(new_s, tag);
    @(negedge clk);
  endtask

  task automatic write_word(int a, logic [W-1:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = AW'(a); wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic write_ctx(int ctx, logic [NB-1:0] c);
    for (int k = 0; k < WORDS; k++) write_word(ctx*WORDS + k, word_of(c, k));
  endtask

  task automatic do_switch(int ctx, logic [NB-1:0] newc, int stray_at,
                           bit with_wr, int wa, logic [W-1:0] wd, string tag);
    logic [NO-1:0] old_e;
    int n;
    old_e = eval(cur_cfg, cur_in);
    @(negedge clk);
    sw_req = 1; sw_ctx = 4'(ctx);
    if (with_wr) begin
      wr_valid = 1; wr_addr = AW'(wa); wr_data = wd;
      chk(wr_ready == 1'b1, "R8 write open with request", int'(wr_ready), 1);
    end
    @(posedge clk); #1;
    sw_req = 0;
    wr_valid = 0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      push(old_e, "R6 old context during switch");
      if (n == stray_at) begin sw_req = 1; sw_ctx = 4'(ctx ^ 1); end
      else sw_req = 0;
      @(posedge clk); #1;
    end
    sw_req = 0;
    chk(n == WORDS + 2, "R5 switch length", n, WORDS + 2);
    cur_cfg = newc;
    @(posedge clk); #1;
    push(eval(newc, cur_in), tag);
    if (stray_at > 0) chk(busy == 1'b0, "R8 request during busy ignored", int'(busy), 0);
    @(negedge clk);
  endtask

  logic [NB-1:0] cfg_a, cfg_b, cfg_c, cfg_b0;

  initial begin
    // context A: all combinational
    cfg_a = '0;
    cfg_a = lit(cfg_a, 0, 0, 0); cfg_a = lit(cfg_a, 0, 1, 0); cfg_a = conn(cfg_a, 0, 0);
    cfg_a = lit(cfg_a, 1, 2, 1); cfg_a = conn(cfg_a, 1, 1);
    cfg_a = lit(cfg_a, 2, 0, 0); cfg_a = conn(cfg_a, 2, 2);
    cfg_a = lit(cfg_a, 3, 3, 0); cfg_a = conn(cfg_a, 2, 3);
    cfg_a[ANDB+ORB +: NO] = 4'b1111;
    // context B: xor pair, constant 1, one registered output
    cfg_b = '0;
    cfg_b = lit(cfg_b, 0, 4, 0); cfg_b = lit(cfg_b, 0, 5, 1); cfg_b = conn(cfg_b, 1, 0);
    cfg_b = lit(cfg_b, 1, 4, 1); cfg_b = lit(cfg_b, 1, 5, 0); cfg_b = conn(cfg_b, 1, 1);
    cfg_b = conn(cfg_b, 0, 5);
    cfg_b = lit(cfg_b, 2, 6, 0); cfg_b = lit(cfg_b, 2, 7, 0); cfg_b = conn(cfg_b, 2, 2);
    cfg_b = lit(cfg_b, 3, 7, 0); cfg_b = conn(cfg_b, 3, 3);
    cfg_b[ANDB+ORB +: NO] = 4'b1011;
    // context C: A with product term 0 replaced by ~x0
    cfg_c = cfg_a;
    cfg_c[0 +: 2*NI] = '0;
    cfg_c = lit(cfg_c, 0, 0, 1);
    // B with its first word cleared
    cfg_b0 = cfg_b;
    cfg_b0[0 +: W] = '0;

    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(pla_out == '0, "R9 outputs after reset", int'(pla_out), 0);
    chk(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
    chk(wr_ready == 1'b1, "R9 ready after reset", int'(wr_ready), 1);

    write_ctx(0, cfg_a);
    write_ctx(1, cfg_b);
    write_ctx(2, cfg_c);
    write_word(2*WORDS, word_of(cfg_a, 0));   // stale first word
    write_ctx(3, cfg_b0);

    set_in(8'hFF, "R9 R3 cleared array reads 0");

    do_switch(0, cfg_a, -1, 0, 0, '0, "R5 context 0 loaded");
    set_in(8'h03, "R1 R2 and-term x0&x1");
    set_in(8'h00, "R1 complement literal");
    set_in(8'h04, "R1 R3 empty sum stays 0");
    set_in(8'h08, "R2 sum of two terms");
    set_in(8'h09, "R2 sum both terms");

    do_switch(1, cfg_b, 4, 0, 0, '0, "R8 stray request, context 1 loaded");
    set_in(8'h10, "R3 empty term gives 1");
    set_in(8'h30, "R1 R2 xor pair");
    set_in(8'hC0, "R4 registered output lags");
    set_in(8'h80, "R4 registered output falls");
    set_in(8'h00, "R2 zero input");

    do_switch(2, cfg_c, -1, 1, 2*WORDS, word_of(cfg_c, 0), "R8 write before switch");
    set_in(8'h01, "R8 corrected word in effect");
    set_in(8'h02, "R8 corrected word in effect");

    fork
      do_switch(3, cfg_b0, -1, 0, 0, '0, "R7 switch sees old word");
      begin
        repeat (3) @(negedge clk);
        chk(wr_ready == 1'b0, "R7 ready low during switch", int'(wr_ready), 0);
        write_word(3*WORDS, word_of(cfg_b, 0));
      end
    join
    set_in(8'h00, "R7 old word still active");
    do_switch(3, cfg_b, -1, 0, 0, '0, "R7 stalled write landed");
    set_in(8'h10, "R7 R5 written word active");

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule